// File: doc/BRIEF.md
# Ring-Scan Battery Source Selector

This block picks one battery out of a bank of parallel sources without any processor involvement. A single circulating token in a ring register points at one candidate at a time. Each candidate has a "voltage good" flag from an external comparator, and that flag is brought into the clock domain before use. When the candidate under the token reports good, its enable output is latched on. Every other enable is cleared in the same clock edge, so the previous source is disconnected only once a replacement has been confirmed (make-before-break).

The token stops moving while any enabled battery is healthy, or while the candidate under the token is good. It resumes stepping when nothing qualifies, for example when the active battery sags below its minimum. An enabled battery that has gone bad stays connected until some other candidate reports good, so the load is never left without a source by the hunt itself. Reset clears every enable and parks the token on battery 0, so a start-up with no good battery cannot leave several sources switched on.

Top module: `batt_ring_selector`

## Requirements
- R1: While `rst_n` is low at a clock edge, all `bat_en_o` bits clear, `src_avail_o` goes low and the token is placed on battery 0.
- R2: Each `bat_good_i` bit is synchronised through two flip-flops. A change becomes visible to the selection logic two clock edges after it is sampled.
- R3: `src_avail_o` is high exactly when the battery under the token has a synchronised good flag. Good flags of batteries not under the token do not affect it.
- R4: When the battery under the token is good, its `bat_en_o` bit is set on the next clock edge.
- R5: When `src_avail_o` is high, every enable of a battery not under the token is cleared on the next edge. At no time is more than one `bat_en_o` bit set.
- R6: When `src_avail_o` is low and no enabled battery has a good flag, the token moves from battery i to battery (i+1) mod N on each clock edge.
- R7: When `src_avail_o` is high, or any enabled battery has a good flag, the token does not move.
- R8: An enabled battery whose good flag drops stays enabled until `src_avail_o` rises for another battery.
- R9: The token register always holds exactly one set bit. Any other value is replaced by battery 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bat_good_i | input | N_SRC | Asynchronous per-battery voltage-good flags from the comparators, bit i for battery i |
| bat_en_o | output | N_SRC | Per-battery switch enable, bit i for battery i |
| src_avail_o | output | 1 | High when the battery under the token is good |

## Verification
The bench goes after hand-overs. A design that cleared the old enable before setting the new one would show a cycle with no enable set. A design that set the new enable without clearing the old one would show two enables at once. A battery that turns good while it is not under the token must be ignored while the active source stays healthy; a design that scanned through a hold would instead switch to it. The bench also drops the active battery while every other battery is bad, to catch a selector that disconnects the load before it has a replacement. A mid-run reset checks that all enables clear.

// File: rtl/bsel_pkg.sv
// Package: shared helpers for the ring-scan battery selector.
// Assumes the bank has at least two sources.
package bsel_pkg;

    // Default number of battery sources in the bank.
    localparam int unsigned BSEL_DEFAULT_SRC = 4;

    // Width-generic token rotation is done in the ring module; this
    // helper reports whether a token vector is legal (exactly one bit set).
    function automatic logic token_legal(input logic [31:0] vec, input int unsigned width);
        int unsigned ones;
        ones = 0;
        for (int unsigned k = 0; k < 32; k++) begin
            if (k < width && vec[k]) ones++;
        end
        return (ones == 1);
    endfunction

endpackage

// File: rtl/bsel_sync_bank.sv
// Module: bsel_sync_bank
// Brings WIDTH asynchronous flags into the clock domain through a chain of
// STAGES flip-flops per bit. Assumes each flag is a slow level (no pulses
// shorter than a clock period need to be caught). Reset clears the chain.
module bsel_sync_bank #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the raw flag through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        end

        assign sync_o[b] = chain_q[LAST];
    end

endmodule

// File: rtl/bsel_ring_ptr.sv
// Module: bsel_ring_ptr
// One-hot token that marks the candidate battery. Rotates one position
// upward (wrapping) when advance_i is high, holds otherwise. A token value
// that is not one-hot is forced back to battery 0. Assumes N_SRC >= 2.
module bsel_ring_ptr #(
    parameter int unsigned N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance_i,
    output logic [N_SRC-1:0] token_o
);
    import bsel_pkg::*;

    localparam logic [N_SRC-1:0] HOME = N_SRC'(1);

    logic [N_SRC-1:0] token_q;
    logic             legal;

    // Legality of the current token value.
    always_comb legal = token_legal(32'(token_q), N_SRC);

    // Token register: reset home, repair, rotate or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         token_q <= HOME;
        else if (!legal)    token_q <= HOME;
        else if (advance_i) token_q <= {token_q[N_SRC-2:0], token_q[N_SRC-1]};
    end

    assign token_o = token_q;

    a_r9_token_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $onehot(token_q));

    a_r6_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i |=> token_q == {$past(token_q[N_SRC-2:0]), $past(token_q[N_SRC-1])});

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(token_q));

endmodule

// File: rtl/bsel_enable_slice.sv
// Module: bsel_enable_slice
// Enable flip-flop of one battery. Set when this battery holds the token and
// is good; cleared when it does not hold the token while another battery is
// available; held otherwise. Assumes avail_i is the OR of all token-masked
// good flags.
module bsel_enable_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic picked_i,
    input  logic good_i,
    input  logic avail_i,
    output logic en_o
);
    logic en_q;

    // Set, clear or hold the switch enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                    en_q <= 1'b0;
        else if (picked_i && good_i)   en_q <= 1'b1;
        else if (!picked_i && avail_i) en_q <= 1'b0;
    end

    assign en_o = en_q;

    a_r4_set_on_good: assert property (@(posedge clk) disable iff (!rst_n)
        (picked_i && good_i) |=> en_q);

    a_r5_drop_on_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (!picked_i && avail_i) |=> !en_q);

    a_r8_keep_until_replaced: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !avail_i) |=> en_q);

endmodule

// File: rtl/batt_ring_selector.sv
// Module: batt_ring_selector (top)
// Hunts for a good battery with a one-hot ring token and switches to it
// make-before-break. Assumes bat_good_i comes from free-running comparators
// and that N_SRC >= 2. Outputs are registered enables plus a combinational
// availability flag derived from registered state.
module batt_ring_selector #(
    parameter int unsigned N_SRC       = bsel_pkg::BSEL_DEFAULT_SRC,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] bat_good_i,
    output logic [N_SRC-1:0] bat_en_o,
    output logic             src_avail_o
);
    logic [N_SRC-1:0] good_s;
    logic [N_SRC-1:0] token;
    logic [N_SRC-1:0] masked_good;
    logic [N_SRC-1:0] en;
    logic             avail;
    logic             active_ok;
    logic             advance;

    bsel_sync_bank #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (bat_good_i),
        .sync_o  (good_s)
    );

    bsel_ring_ptr #(.N_SRC(N_SRC)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (advance),
        .token_o   (token)
    );

    // Only the battery under the token may report availability.
    always_comb begin
        masked_good = token & good_s;
        avail       = |masked_good;
        active_ok   = |(en & good_s);
        advance     = !avail && !active_ok;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_slice
        bsel_enable_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .picked_i (token[i]),
            .good_i   (good_s[i]),
            .avail_i  (avail),
            .en_o     (en[i])
        );
    end

    assign bat_en_o    = en;
    assign src_avail_o = avail;

    a_r5_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $onehot0(bat_en_o));

    a_r3_avail_gets_enable: assert property (@(posedge clk) disable iff (!rst_n)
        src_avail_o |=> $countones(bat_en_o) == 1);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (bat_en_o == '0) && !src_avail_o);

endmodule

// File: tb/batt_ring_selector_tb.sv
// Bench: behavioural reference model compared on every clock, plus named
// scenario checks for each requirement.
module batt_ring_selector_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] bat_good_i = '0;
    logic [N-1:0] bat_en_o;
    logic         src_avail_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // Reference model state.
    bit [N-1:0] m_s1, m_s2, m_en;
    int         m_ptr;

    always #4 clk = ~clk;

    batt_ring_selector #(.N_SRC(N)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bat_good_i  (bat_good_i),
        .bat_en_o    (bat_en_o),
        .src_avail_o (src_avail_o)
    );

    // Model update from the requirements, using pre-edge values.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_en = '0; m_ptr = 0;
        end else begin
            bit avail, healthy;
            bit [N-1:0] en_n;
            avail   = m_s2[m_ptr];
            healthy = 0;
            for (int i = 0; i < N; i++) if (m_en[i] && m_s2[i]) healthy = 1;
            en_n = m_en;
            for (int i = 0; i < N; i++) begin
                if (i == m_ptr && m_s2[i]) en_n[i] = 1;
                else if (i != m_ptr && avail) en_n[i] = 0;
            end
            m_en = en_n;
            if (!avail && !healthy) m_ptr = (m_ptr + 1) % N;
            m_s2 = m_s1;
            m_s1 = bat_good_i;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(bat_en_o == m_en, "R4 R5 R8 enable vs model", bat_en_o, m_en);
            check(src_avail_o == m_s2[m_ptr], "R3 R6 R7 avail vs model", src_avail_o, m_s2[m_ptr]);
            check($countones(bat_en_o) <= 1, "R5 at most one enable", $countones(bat_en_o), 1);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cycles(3);
        // R1: reset state.
        check(bat_en_o == '0, "R1 enables after reset", bat_en_o, 0);
        check(src_avail_o == 1'b0, "R1 avail after reset", src_avail_o, 0);
        rst_n = 1'b1;

        // R6: hunting with all bad, nothing enabled.
        cycles(9);
        check(bat_en_o == '0, "R6 no enable while hunting", bat_en_o, 0);

        // R2: battery 2 good; not visible before two edges.
        bat_good_i = 4'b0100;
        cycles(1);
        check(bat_en_o == '0, "R2 no effect after one edge", bat_en_o, 0);
        cycles(8);
        check(bat_en_o == 4'b0100, "R4 battery 2 enabled", bat_en_o, 4'b0100);
        check(src_avail_o == 1'b1, "R7 token parked on battery 2", src_avail_o, 1);

        // R3: another battery turns good while battery 2 is healthy: ignored.
        bat_good_i = 4'b0110;
        cycles(10);
        check(bat_en_o == 4'b0100, "R3 unselected good ignored", bat_en_o, 4'b0100);

        // R8: battery 2 drops with all others bad: stays enabled.
        bat_good_i = 4'b0000;
        cycles(12);
        check(bat_en_o == 4'b0100, "R8 bad source kept until replaced", bat_en_o, 4'b0100);
        check(src_avail_o == 1'b0, "R8 nothing available", src_avail_o, 0);

        // R5: battery 0 turns good: hand-over, old cleared.
        bat_good_i = 4'b0001;
        cycles(10);
        check(bat_en_o == 4'b0001, "R5 hand-over to battery 0", bat_en_o, 4'b0001);

        // R7: battery 3 good too; token held on healthy battery 0.
        bat_good_i = 4'b1001;
        cycles(10);
        check(bat_en_o == 4'b0001, "R7 hold while active healthy", bat_en_o, 4'b0001);

        // R6: battery 0 drops; scan moves to battery 3.
        bat_good_i = 4'b1000;
        cycles(12);
        check(bat_en_o == 4'b1000, "R6 scan finds battery 3", bat_en_o, 4'b1000);

        // Several batteries good while hunting from a bad active source.
        bat_good_i = 4'b0000;
        cycles(3);
        bat_good_i = 4'b0110;
        cycles(12);
        check($countones(bat_en_o) == 1, "R5 single enable after multi-good", $countones(bat_en_o), 1);

        // R1: mid-run reset.
        @(negedge clk) rst_n = 1'b0;
        cycles(2);
        check(bat_en_o == '0, "R1 mid-run reset clears enables", bat_en_o, 0);
        check(src_avail_o == 1'b0, "R1 mid-run reset clears avail", src_avail_o, 0);
        rst_n = 1'b1;
        bat_good_i = 4'b0001;
        cycles(6);
        check(bat_en_o == 4'b0001, "R1 token restarts at battery 0", bat_en_o, 4'b0001);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule